// File: doc/BRIEF.md
# Suspend and Wake-Up Sequencer

This block sequences a programmable device into and out of a low-power suspend state. A SUSPEND request stops global writes, puts the user outputs into tristate and pauses the background configuration CRC checker. When the request is withdrawn, the block releases a shared AWAKE handshake line. An external controller or sibling devices wired to the same line can keep it low, and the return to active mode stalls until the sensed line reads high. Two release counters then re-enable writes first and take the outputs out of tristate second, after programmed numbers of cycles.

The AWAKE output supports two drive modes. In open-drain mode it can only pull low and relies on an external pull-up. In push-pull mode it is driven both ways. A CRC error reported by the checker is latched. While it is latched, the block cannot leave suspend until the reprogram input is pulsed. Reprogramming clears the latch and reruns the release sequence. SUSPEND and the sensed AWAKE level are asynchronous and pass through two-flop synchronizers.

Top module: `suspend_sequencer`

## Requirements
- R1: After reset the block is active: gweOut=1, gtsOut=0 (outputs not tristated), crcCheckEn=1, and in open-drain mode (pushPull=0) awakeOe=0.
- R2: Three clock edges after suspendIn rises, and for as long as the block stays suspended, gweOut=0, gtsOut=1 and crcCheckEn=0.
- R3: Drive mode. With pushPull=0, awakeOut is always 0 and awakeOe=1 only while the line is held low. With pushPull=1, awakeOe is always 1 and awakeOut carries the awake level. The line is held low from suspend entry until suspend is withdrawn.
- R4: With no CRC error, the AWAKE line is released on the third clock edge after suspendIn falls.
- R5: The release counters do not start or advance while the synchronized sensed AWAKE level is low. They begin on the third edge after the sensed line goes high. gweOut rises GWE_CYCLES edges later and gtsOut falls GTS_CYCLES edges later (GTS_CYCLES >= GWE_CYCLES >= 1), so outputs never leave tristate while writes are disabled.
- R6: One edge after gtsOut falls, the block is active again and crcCheckEn=1.
- R7: A crcErrIn pulse at any time before or during suspend, including in the very cycle in which the synchronized SUSPEND falls, blocks every exit from suspend. The line stays held low and gweOut stays 0.
- R8: While reprogIn is high, the CRC error latch is cleared and gweOut=0, gtsOut=1. After reprogIn falls, the release sequence runs and the block becomes active.
- R9: If suspendIn rises again while the block waits for the AWAKE line, the block returns to suspend and drives the line low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| suspendIn | input | 1 | Asynchronous suspend request |
| awakeSense | input | 1 | Sensed level of the shared AWAKE line |
| crcErrIn | input | 1 | Error flag from the background CRC checker |
| reprogIn | input | 1 | Reprogram request, synchronous |
| pushPull | input | 1 | AWAKE drive mode: 1 push-pull, 0 open-drain |
| awakeOut | output | 1 | AWAKE output value |
| awakeOe | output | 1 | AWAKE output enable |
| gweOut | output | 1 | Global write enable |
| gtsOut | output | 1 | Global tristate, 1 = user outputs tristated |
| crcCheckEn | output | 1 | Enable for the background CRC checker |

## Verification
Two functions can collide in one cycle: a CRC error report and the exit from suspend, on the same edge where the synchronized SUSPEND falls. The bench counts clock edges from the suspendIn deassertion and pulses crcErrIn for exactly that one cycle. It then judges the result at the ports: the AWAKE line must stay held low and gweOut must stay 0 until a reprogram pulse. The release counts are judged separately, edge by edge, against indices computed from the external hold length and the two count parameters.

// File: rtl/susp_pkg.sv
package susp_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_ENTER,
    ST_SUSP,
    ST_WAIT,
    ST_COUNT
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic crcClr;
    logic awakeRel;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic suspS;
    logic awakeS;
    logic crcBlock;
    logic gweDone;
    logic gtsDone;
  } seqStatus_t;

endpackage

// File: rtl/susp_dpath.sv
module susp_dpath
  import susp_pkg::*;
#(
  parameter int GWE_CYCLES  = 4,
  parameter int GTS_CYCLES  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       suspendIn,
  input  logic       awakeSense,
  input  logic       crcErrIn,
  input  logic       pushPull,
  input  seqStrobe_t strobe,
  output seqStatus_t status,
  output logic       awakeOut,
  output logic       awakeOe
);

  localparam int LAST  = (GTS_CYCLES > GWE_CYCLES) ? GTS_CYCLES : GWE_CYCLES;
  localparam int CNT_W = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] GWE_L  = CNT_W'(GWE_CYCLES);
  localparam logic [CNT_W-1:0] GTS_L  = CNT_W'(GTS_CYCLES);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(LAST);

  logic [SYNC_STAGES-1:0] suspPipe;
  logic [SYNC_STAGES-1:0] awakePipe;
  logic                   crcLatch;
  logic [CNT_W-1:0]       relCnt;

  // synchronizers for the asynchronous inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspPipe  <= '0;
      awakePipe <= '0;
    end else begin
      suspPipe  <= {suspPipe[SYNC_STAGES-2:0], suspendIn};
      awakePipe <= {awakePipe[SYNC_STAGES-2:0], awakeSense};
    end
  end

  // CRC error latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             crcLatch <= 1'b0;
    else if (strobe.crcClr) crcLatch <= 1'b0;
    else if (crcErrIn)      crcLatch <= 1'b1;
  end

  // release counter, frozen while the sensed line is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                relCnt <= '0;
    else if (strobe.cntClr)   relCnt <= '0;
    else if (strobe.cntEn && awakePipe[SYNC_STAGES-1] && relCnt != LAST_L)
      relCnt <= relCnt + 1'b1;
  end

  always_comb begin
    status.suspS    = suspPipe[SYNC_STAGES-1];
    status.awakeS   = awakePipe[SYNC_STAGES-1];
    status.crcBlock = crcLatch | (crcErrIn & ~strobe.crcClr);
    status.gweDone  = (relCnt >= GWE_L);
    status.gtsDone  = (relCnt >= GTS_L);
  end

  // AWAKE pad control
  always_comb begin
    if (pushPull) begin
      awakeOe  = 1'b1;
      awakeOut = strobe.awakeRel;
    end else begin
      awakeOe  = ~strobe.awakeRel;
      awakeOut = 1'b0;
    end
  end

  // R5
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cntClr && !awakePipe[SYNC_STAGES-1]) |=> $stable(relCnt));

  // R3
  held_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.awakeRel |-> (awakeOe && !awakeOut));

endmodule

// File: rtl/susp_ctrl.sv
module susp_ctrl
  import susp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reprogIn,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       gweOut,
  output logic       gtsOut,
  output logic       crcCheckEn
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    if (reprogIn) begin
      nextState = ST_COUNT;
    end else begin
      unique case (state)
        ST_ACTIVE: if (status.suspS) nextState = ST_ENTER;
        ST_ENTER:  nextState = ST_SUSP;
        ST_SUSP:   if (!status.suspS && !status.crcBlock) nextState = ST_WAIT;
        ST_WAIT: begin
          if (status.suspS)       nextState = ST_SUSP;
          else if (status.awakeS) nextState = ST_COUNT;
        end
        ST_COUNT: begin
          if (status.suspS) nextState = ST_ENTER;
          else if (status.gweDone && status.gtsDone) nextState = ST_ACTIVE;
        end
        default: nextState = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= nextState;
  end

  always_comb begin
    strobe.cntClr   = reprogIn || (state != ST_COUNT);
    strobe.cntEn    = (state == ST_COUNT);
    strobe.crcClr   = reprogIn;
    strobe.awakeRel = (state == ST_WAIT) || (state == ST_COUNT) || (state == ST_ACTIVE);
    gweOut     = (state == ST_ACTIVE) || ((state == ST_COUNT) && status.gweDone);
    gtsOut     = !((state == ST_ACTIVE) || ((state == ST_COUNT) && status.gtsDone));
    crcCheckEn = (state == ST_ACTIVE);
  end

  // R5
  gts_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gtsOut |-> gweOut);

  // R7
  blocked_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && status.crcBlock && !reprogIn) |=> state == ST_SUSP);

  // R4
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !status.awakeS && !status.suspS && !reprogIn) |=> state == ST_WAIT);

  // R8
  reprog_chk: assert property (@(posedge clk) disable iff (!rstN)
    reprogIn |=> (state == ST_COUNT && !gweOut && gtsOut));

  // R2
  crc_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.awakeRel |-> (!crcCheckEn && !gweOut && gtsOut));

endmodule

// File: rtl/suspend_sequencer.sv
module suspend_sequencer
  import susp_pkg::*;
#(
  parameter int GWE_CYCLES  = 4,
  parameter int GTS_CYCLES  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic suspendIn,
  input  logic awakeSense,
  input  logic crcErrIn,
  input  logic reprogIn,
  input  logic pushPull,
  output logic awakeOut,
  output logic awakeOe,
  output logic gweOut,
  output logic gtsOut,
  output logic crcCheckEn
);

  seqStrobe_t strobe;
  seqStatus_t status;

  susp_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reprogIn   (reprogIn),
    .status     (status),
    .strobe     (strobe),
    .gweOut     (gweOut),
    .gtsOut     (gtsOut),
    .crcCheckEn (crcCheckEn)
  );

  susp_dpath #(
    .GWE_CYCLES  (GWE_CYCLES),
    .GTS_CYCLES  (GTS_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .suspendIn  (suspendIn),
    .awakeSense (awakeSense),
    .crcErrIn   (crcErrIn),
    .pushPull   (pushPull),
    .strobe     (strobe),
    .status     (status),
    .awakeOut   (awakeOut),
    .awakeOe    (awakeOe)
  );

  // R3
  open_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pushPull && crcCheckEn) |-> !awakeOe);

endmodule

// File: tb/test_suspend_sequencer.sv
module test_suspend_sequencer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic suspendIn = 1'b0;
  logic crcErrIn = 1'b0;
  logic reprogIn = 1'b0;
  logic pushPull = 1'b0;
  logic extLow = 1'b0;
  logic awakeSense;
  logic awakeOut, awakeOe, gweOut, gtsOut, crcCheckEn;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // wired AWAKE line: external hold wins, otherwise driven value or pull-up
  assign awakeSense = extLow ? 1'b0 : (awakeOe ? awakeOut : 1'b1);

  suspend_sequencer i_suspend_sequencer (
    .clk(clk), .rstN(rstN), .suspendIn(suspendIn), .awakeSense(awakeSense),
    .crcErrIn(crcErrIn), .reprogIn(reprogIn), .pushPull(pushPull),
    .awakeOut(awakeOut), .awakeOe(awakeOe), .gweOut(gweOut), .gtsOut(gtsOut),
    .crcCheckEn(crcCheckEn)
  );

  typedef struct packed {
    logic       pp;
    logic [7:0] hold;
    logic [7:0] gweIdx;
    logic [7:0] gtsIdx;
    logic [7:0] actIdx;
  } vec_t;

  // gweIdx = hold+3+4, gtsIdx = hold+3+6, actIdx = gtsIdx+1
  localparam vec_t VECS [4] = '{
    '{1'b0, 8'd0, 8'd7,  8'd9,  8'd10},
    '{1'b0, 8'd5, 8'd12, 8'd14, 8'd15},
    '{1'b1, 8'd0, 8'd7,  8'd9,  8'd10},
    '{1'b1, 8'd3, 8'd10, 8'd12, 8'd13}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic released();
    return pushPull ? awakeOut : !awakeOe;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(4);
    rstN = 1'b1;
    cyc(1);
    // R1
    chk("R1 gwe,gts,crcEn,oe", {4'd0, gweOut, gtsOut, crcCheckEn, awakeOe}, 8'b0000_1010);

    foreach (VECS[v]) begin
      vec_t vc;
      int found;
      vc = VECS[v];
      pushPull = vc.pp;
      suspendIn = 1'b1;
      cyc(8);
      // R2
      chk("R2 suspended gwe,gts,crcEn", {5'd0, gweOut, gtsOut, crcCheckEn}, 8'b010);
      // R3
      chk("R3 line held low oe,out", {6'd0, awakeOe, awakeOut}, 8'b10);
      extLow = (vc.hold != 0);
      suspendIn = 1'b0;
      found = 0;
      for (int p = 1; p <= 10; p++) begin
        @(negedge clk);
        if (released()) begin found = p; break; end
      end
      // R4
      chk("R4 release latency", 8'(found), 8'd3);
      for (int idx = 0; idx <= 20; idx++) begin
        if (idx > 0) @(negedge clk);
        // R5 R6
        chk("R5/R6 release sequence",
            {5'd0, gweOut, gtsOut, crcCheckEn},
            {5'd0, (idx >= int'(vc.gweIdx)), (idx < int'(vc.gtsIdx)), (idx >= int'(vc.actIdx))});
        if (idx == int'(vc.hold)) extLow = 1'b0;
      end
      // R3
      chk("R3 released oe,out", {6'd0, awakeOe, awakeOut}, vc.pp ? 8'b11 : 8'b00);
    end
    pushPull = 1'b0;
    cyc(2);

    // R7: error reported during suspend blocks exit
    suspendIn = 1'b1;
    cyc(6);
    crcErrIn = 1'b1;
    cyc(1);
    crcErrIn = 1'b0;
    cyc(4);
    suspendIn = 1'b0;
    cyc(20);
    chk("R7 blocked gwe,oe,out", {5'd0, gweOut, awakeOe, awakeOut}, 8'b010);
    // R8
    reprogIn = 1'b1;
    cyc(3);
    chk("R8 during reprog gwe,gts", {6'd0, gweOut, gtsOut}, 8'b01);
    reprogIn = 1'b0;
    cyc(30);
    chk("R8 after reprog gwe,gts,crcEn", {5'd0, gweOut, gtsOut, crcCheckEn}, 8'b101);

    // R7: error in the same cycle the synchronized suspend falls
    suspendIn = 1'b1;
    cyc(8);
    suspendIn = 1'b0;
    cyc(2);
    crcErrIn = 1'b1;
    cyc(1);
    crcErrIn = 1'b0;
    cyc(15);
    chk("R7 same-cycle block gwe,oe,out", {5'd0, gweOut, awakeOe, awakeOut}, 8'b010);
    reprogIn = 1'b1;
    cyc(1);
    reprogIn = 1'b0;
    cyc(30);
    chk("R8 recovery gwe,gts,crcEn", {5'd0, gweOut, gtsOut, crcCheckEn}, 8'b101);

    // R9: suspend reasserted while waiting for the line
    suspendIn = 1'b1;
    cyc(8);
    extLow = 1'b1;
    suspendIn = 1'b0;
    cyc(10);
    chk("R4 waiting released oe", {7'd0, awakeOe}, 8'd0);
    chk("R5 frozen while held gwe,gts", {6'd0, gweOut, gtsOut}, 8'b01);
    suspendIn = 1'b1;
    cyc(6);
    chk("R9 re-suspend oe,out", {6'd0, awakeOe, awakeOut}, 8'b10);
    extLow = 1'b0;
    suspendIn = 1'b0;
    cyc(30);
    chk("R9 final active gwe,gts,crcEn", {5'd0, gweOut, gtsOut, crcCheckEn}, 8'b101);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule